// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block turns one posted bus write into the whole command and address phase of a NAND flash access. The write address carries the opcodes and the shape of the sequence: a first command byte, an optional second command byte, a flag that enables the second command, and an address-cycle count. The write data carries up to four address bytes. A fifth address byte comes from a separate 8-bit register, loaded before the command write. The write is accepted in the cycle it is presented, with no stall. The sequencer then drives the command-latch and address-latch enables, the write strobe and the 8-bit I/O bus one byte at a time.

When the second command is enabled, the block waits for the device's ready line to fall and then rise again before it counts the operation as finished. A timeout bounds this wait. One further write may be queued behind the running sequence. A write that finds the queue already full is dropped and flagged. A read returns a status word that does not depend on any address. The read strobe clears the sticky error flags.

Top module: `nand_cmd_seq`

## Requirements
- R1: A write carries the first opcode in busAddr[7:0], the second opcode in busAddr[15:8], the address-cycle count in busAddr[18:16] and the second-command enable in busAddr[19]. The first byte driven is always the first opcode, with nandCle=1 and nandAle=0.
- R2: After the first opcode, min(count,5) address bytes follow with nandAle=1 and nandCle=0, in this order: busWrData[7:0], [15:8], [23:16], [31:24], then the extra address byte. Counts of 6 and 7 act as 5.
- R3: The second opcode is driven, with nandCle=1 and nandAle=0, after the address bytes, and only when busAddr[19]=1.
- R4: For each byte, nandWeN is low for WE_LOW clocks and then high for WE_HIGH clocks, and nandIo holds steady while nandWeN is low. Without a second command, busy lasts exactly n*(WE_LOW+WE_HIGH) clocks after the write, where n is the number of bytes.
- R5: busRdData reports bit0 busy, bit1 queue full, bit2 timeout, bit3 overflow, and zero elsewhere. Out of reset it is 0, with nandWeN=1, nandCle=nandAle=0 and nandIoOe=0.
- R6: After the second opcode, busy stays set while nandReady is low. Busy clears within four clocks after nandReady returns high.
- R7: If the ready wait lasts TIMEOUT clocks, the timeout bit is set and busy clears. Busy then lasts n*(WE_LOW+WE_HIGH)+TIMEOUT clocks in total.
- R8: A write accepted while busy is queued (bit1=1). It runs right after the current sequence, with one idle clock between them, and busy stays set throughout.
- R9: A write while the queue is full is dropped: its bytes never appear, and the overflow bit is set.
- R10: busRdEn clears the timeout and overflow bits on the next clock, unless a new event sets them in that same clock.
- R11: The extra address byte is captured at the moment of the command write. Reloading it afterwards does not change a sequence already accepted.
- R12: A count of 0 with the enable clear issues only the first opcode, a single byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Command write strobe |
| busAddr | input | ADDR_W | Write address: opcodes, count, enable |
| busWrData | input | 32 | Address bytes 1 to 4 |
| busRdEn | input | 1 | Status read strobe, clears sticky flags |
| busRdData | output | 32 | Status word |
| extByteWr | input | 1 | Load strobe for the extra address byte |
| extByteData | input | 8 | Extra (fifth) address byte |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandIo | output | 8 | I/O bus byte |
| nandIoOe | output | 1 | I/O bus drive enable |
| nandReady | input | 1 | Device ready (low while busy) |

## Verification
The hardest state to reach is the queue interplay: a second write has to land while a sequence runs, and a third has to arrive while that second one is still waiting. The bench issues back-to-back writes on consecutive clocks right after a start, so all three fall inside the first byte. The ready line is driven by the bench itself, which holds it low for a set time or never lowers it at all, so that both the normal completion and the timeout path are forced on demand.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int OP1_LSB    = 0;
  localparam int OP2_LSB    = 8;
  localparam int CNT_LSB    = 16;
  localparam int OP2_EN_BIT = 19;
  localparam int MAX_ADDR   = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP1, ST_ADDR, ST_OP2, ST_WAIT_LOW, ST_WAIT_HIGH
  } seqState_e;

  typedef enum logic [1:0] {
    SEL_NONE, SEL_OP1, SEL_ADDR, SEL_OP2
  } byteSel_e;

  typedef struct packed {
    logic     loadActBus;
    logic     loadActPend;
    logic     loadPend;
    byteSel_e sel;
    logic [2:0] addrIdx;
    logic     weLow;
  } seqStrobe_t;

  typedef struct packed {
    logic [7:0]  op1;
    logic [7:0]  op2;
    logic [2:0]  addrCnt;
    logic        op2En;
    logic [39:0] addrBytes;
  } nandJob_t;

endpackage

// File: rtl/nand_seq_datapath.sv
module nand_seq_datapath
  import nand_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  input  logic              extByteWr,
  input  logic [7:0]        extByteData,
  output logic [2:0]        jobAddrCnt,
  output logic              jobOp2En,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic [7:0]        nandIo,
  output logic              nandIoOe
);

  logic [7:0] extReg;
  nandJob_t   incoming;
  nandJob_t   actJob;
  nandJob_t   pendJob;
  logic [2:0] rawCnt;
  logic [39:0] shifted;

  always_ff @(posedge clk) begin
    if (!rstN)          extReg <= '0;
    else if (extByteWr) extReg <= extByteData;
  end

  always_comb begin
    rawCnt             = busAddr[CNT_LSB +: 3];
    incoming.op1       = busAddr[OP1_LSB +: 8];
    incoming.op2       = busAddr[OP2_LSB +: 8];
    incoming.op2En     = busAddr[OP2_EN_BIT];
    incoming.addrCnt   = (rawCnt > 3'(MAX_ADDR)) ? 3'(MAX_ADDR) : rawCnt;
    incoming.addrBytes = {extReg, busWrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actJob  <= '0;
      pendJob <= '0;
    end else begin
      if (stb.loadActBus)       actJob <= incoming;
      else if (stb.loadActPend) actJob <= pendJob;
      if (stb.loadPend)         pendJob <= incoming;
    end
  end

  assign jobAddrCnt = actJob.addrCnt;
  assign jobOp2En   = actJob.op2En;
  assign shifted    = actJob.addrBytes >> {stb.addrIdx, 3'b000};

  always_comb begin
    nandCle  = 1'b0;
    nandAle  = 1'b0;
    nandIo   = '0;
    nandIoOe = 1'b1;
    unique case (stb.sel)
      SEL_OP1: begin
        nandCle = 1'b1;
        nandIo  = actJob.op1;
      end
      SEL_ADDR: begin
        nandAle = 1'b1;
        nandIo  = shifted[7:0];
      end
      SEL_OP2: begin
        nandCle = 1'b1;
        nandIo  = actJob.op2;
      end
      default: nandIoOe = 1'b0;
    endcase
    nandWeN = ~stb.weLow;
  end

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int WE_LOW  = 3,
  parameter int WE_HIGH = 2,
  parameter int TIMEOUT = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [2:0]  jobAddrCnt,
  input  logic        jobOp2En,
  input  logic        nandReady,
  output seqStrobe_t  stb,
  output logic [31:0] statusWord
);

  localparam int W_MAX = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int CNT_W = (W_MAX < 2) ? 1 : $clog2(W_MAX);
  localparam int TMO_W = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);

  seqState_e  state;
  seqState_e  afterByte;
  logic [2:0] addrIdx, afterIdx;
  logic       phaseHigh;
  logic [CNT_W-1:0] weCnt;
  logic [TMO_W-1:0] tmoCnt;
  logic       pendValid, errFlag, ovfFlag;
  logic [1:0] rdySync;
  logic       rdy;
  logic       idle, startSeq, reject, byteState, lowDone, byteDone;
  logic       waiting, tmoHit;

  assign rdy       = rdySync[1];
  assign idle      = (state == ST_IDLE);
  assign byteState = (state == ST_OP1) || (state == ST_ADDR) || (state == ST_OP2);
  assign lowDone   = byteState && !phaseHigh && (weCnt == CNT_W'(WE_LOW - 1));
  assign byteDone  = byteState &&  phaseHigh && (weCnt == CNT_W'(WE_HIGH - 1));
  assign waiting   = (state == ST_WAIT_LOW) || (state == ST_WAIT_HIGH);
  assign tmoHit    = waiting && (tmoCnt == TMO_W'(TIMEOUT - 1)) &&
                     !((state == ST_WAIT_HIGH) && rdy);
  assign startSeq  = idle && (pendValid || busWrEn);
  assign reject    = !idle && pendValid && busWrEn;

  always_comb begin
    stb             = '0;
    stb.loadActBus  = idle && !pendValid && busWrEn;
    stb.loadActPend = idle && pendValid;
    stb.loadPend    = busWrEn && (idle ? pendValid : !pendValid);
    stb.addrIdx     = addrIdx;
    stb.weLow       = byteState && !phaseHigh;
    unique case (state)
      ST_OP1:  stb.sel = SEL_OP1;
      ST_ADDR: stb.sel = SEL_ADDR;
      ST_OP2:  stb.sel = SEL_OP2;
      default: stb.sel = SEL_NONE;
    endcase
  end

  always_comb begin
    afterByte = ST_IDLE;
    afterIdx  = '0;
    unique case (state)
      ST_OP1: begin
        if (jobAddrCnt != 3'd0) afterByte = ST_ADDR;
        else if (jobOp2En)      afterByte = ST_OP2;
      end
      ST_ADDR: begin
        if ((addrIdx + 3'd1) < jobAddrCnt) begin
          afterByte = ST_ADDR;
          afterIdx  = addrIdx + 3'd1;
        end else if (jobOp2En) begin
          afterByte = ST_OP2;
        end
      end
      ST_OP2:  afterByte = ST_WAIT_LOW;
      default: afterByte = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdySync <= 2'b11;
    else       rdySync <= {rdySync[0], nandReady};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      errFlag   <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      if (stb.loadPend)         pendValid <= 1'b1;
      else if (stb.loadActPend) pendValid <= 1'b0;
      if (reject)       ovfFlag <= 1'b1;
      else if (busRdEn) ovfFlag <= 1'b0;
      if (tmoHit)       errFlag <= 1'b1;
      else if (busRdEn) errFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseHigh <= 1'b0;
      weCnt     <= '0;
      addrIdx   <= '0;
      tmoCnt    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startSeq) begin
            state     <= ST_OP1;
            phaseHigh <= 1'b0;
            weCnt     <= '0;
            addrIdx   <= '0;
          end
        end
        ST_OP1, ST_ADDR, ST_OP2: begin
          if (lowDone) begin
            phaseHigh <= 1'b1;
            weCnt     <= '0;
          end else if (byteDone) begin
            phaseHigh <= 1'b0;
            weCnt     <= '0;
            state     <= afterByte;
            addrIdx   <= afterIdx;
            tmoCnt    <= '0;
          end else begin
            weCnt <= weCnt + 1'b1;
          end
        end
        ST_WAIT_LOW: begin
          if (tmoHit) state <= ST_IDLE;
          else begin
            tmoCnt <= tmoCnt + 1'b1;
            if (!rdy) state <= ST_WAIT_HIGH;
          end
        end
        ST_WAIT_HIGH: begin
          if (tmoHit || rdy) state <= ST_IDLE;
          else               tmoCnt <= tmoCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign statusWord = {28'd0, ovfFlag, errFlag, pendValid, (!idle || pendValid)};

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int WE_LOW  = 3,
  parameter int WE_HIGH = 2,
  parameter int TIMEOUT = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  input  logic              extByteWr,
  input  logic [7:0]        extByteData,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic [7:0]        nandIo,
  output logic              nandIoOe,
  input  logic              nandReady
);

  seqStrobe_t stb;
  logic [2:0] jobAddrCnt;
  logic       jobOp2En;

  nand_seq_ctrl #(
    .WE_LOW (WE_LOW),
    .WE_HIGH(WE_HIGH),
    .TIMEOUT(TIMEOUT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .jobAddrCnt(jobAddrCnt),
    .jobOp2En  (jobOp2En),
    .nandReady (nandReady),
    .stb       (stb),
    .statusWord(busRdData)
  );

  nand_seq_datapath #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .extByteWr  (extByteWr),
    .extByteData(extByteData),
    .jobAddrCnt (jobAddrCnt),
    .jobOp2En   (jobOp2En),
    .nandCle    (nandCle),
    .nandAle    (nandAle),
    .nandWeN    (nandWeN),
    .nandIo     (nandIo),
    .nandIoOe   (nandIoOe)
  );

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic              busRdEn,
  input logic [31:0]       busRdData,
  input logic              extByteWr,
  input logic [7:0]        extByteData,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandWeN,
  input logic [7:0]        nandIo,
  input logic              nandIoOe,
  input logic              nandReady
);

  // R1
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  // R4
  io_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN && $past(!nandWeN)) |-> $stable(nandIo));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdData[0] |-> (nandWeN && !nandCle && !nandAle && !nandIoOe));

  // R8
  write_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> busRdData[0]);

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRdData[3]) |-> ($past(busWrEn) && $past(busRdData[1])));

  // R7
  tmo_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRdData[2]) |-> ($past(busRdData[0]) && !busRdData[0]));

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn) |=> !busRdData[3]);

endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;

  localparam int ADDR_W = 20;
  localparam int WL     = 2;
  localparam int WH     = 1;
  localparam int TMO    = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        extByteWr = 1'b0;
  logic [7:0]  extByteData = '0;
  logic        nandCle, nandAle, nandWeN, nandIoOe;
  logic [7:0]  nandIo;
  logic        nandReady = 1'b1;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  nand_cmd_seq #(.ADDR_W(ADDR_W), .WE_LOW(WL), .WE_HIGH(WH), .TIMEOUT(TMO)) uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .extByteWr(extByteWr), .extByteData(extByteData), .nandCle(nandCle),
    .nandAle(nandAle), .nandWeN(nandWeN), .nandIo(nandIo),
    .nandIoOe(nandIoOe), .nandReady(nandReady)
  );

  // byte capture: {cle, ale, io}
  logic [9:0] cap [0:31];
  int capN = 0;
  logic [9:0] lastByte = '0;
  logic prevWe = 1'b1;
  int lowRun = 0;
  int busyCnt = 0;
  logic busyCntEn = 1'b0;

  logic [9:0] expSeq [0:31];
  int expN = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (!nandWeN) begin
        lowRun++;
        lastByte = {nandCle, nandAle, nandIo};
      end else if (!prevWe) begin
        if (capN < 32) cap[capN] = lastByte;
        capN++;
        check(lowRun == WL, "R4 low width", lowRun, WL);
        lowRun = 0;
      end
      prevWe = nandWeN;
      if (busyCntEn && busRdData[0]) busyCnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  function automatic logic [ADDR_W-1:0] mkAddr(input logic [7:0] op1, input logic [7:0] op2,
                                               input int cnt, input bit en);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[7:0]   = op1;
    a[15:8]  = op2;
    a[18:16] = 3'(cnt);
    a[19]    = en;
    return a;
  endfunction

  task automatic appendExp(input logic [7:0] op1, input logic [7:0] op2, input int cnt,
                           input bit en, input logic [31:0] data, input logic [7:0] ext);
    int n;
    n = (cnt > 5) ? 5 : cnt;
    expSeq[expN] = {2'b10, op1}; expN++;
    for (int i = 0; i < n; i++) begin
      expSeq[expN] = {2'b01, (i < 4) ? data[8*i +: 8] : ext};
      expN++;
    end
    if (en) begin
      expSeq[expN] = {2'b10, op2}; expN++;
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic loadExt(input logic [7:0] v);
    extByteData = v; extByteWr = 1'b1;
    @(negedge clk);
    extByteWr = 1'b0;
  endtask

  task automatic readStatus();
    busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic startCapture();
    capN = 0; expN = 0; busyCnt = 0; busyCntEn = 1'b1;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 2000 && busRdData[0]; k++) @(negedge clk);
  endtask

  task automatic compareSeq(input string req);
    check(capN == expN, req, capN, expN);
    for (int i = 0; i < expN && i < capN; i++)
      check(cap[i] == expSeq[i], req, cap[i], expSeq[i]);
  endtask

  // one sequence with bench-driven ready line
  task automatic runOne(input logic [7:0] op1, input logic [7:0] op2, input int cnt,
                        input bit en, input logic [31:0] data, input logic [7:0] ext);
    int n;
    loadExt(ext);
    startCapture();
    appendExp(op1, op2, cnt, en, data, ext);
    n = expN;
    busWrite(mkAddr(op1, op2, cnt, en), data);
    if (en) begin
      for (int k = 0; k < 500 && capN < n; k++) @(negedge clk);
      repeat (3) @(negedge clk);
      nandReady = 1'b0;
      repeat (6) @(negedge clk);
      check(busRdData[0] == 1'b1, "R6 busy while not ready", busRdData[0], 1);
      nandReady = 1'b1;
      repeat (4) @(negedge clk);
      check(busRdData[0] == 1'b0, "R6 busy clears after ready", busRdData[0], 0);
    end else begin
      waitIdle();
      check(busyCnt == n * (WL + WH), "R4 busy length", busyCnt, n * (WL + WH));
    end
    busyCntEn = 1'b0;
    if (cnt == 0 && !en) check(capN == 1, "R12 single opcode", capN, 1);
    if (cnt > 5) compareSeq("R2 clamp");
    else if (en) compareSeq("R3 second opcode");
    else compareSeq("R1 R2 order");
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busRdData == 32'd0, "R5 reset status", busRdData, 0);
    check(nandWeN && !nandCle && !nandAle && !nandIoOe, "R5 reset pins",
          {nandWeN, nandCle, nandAle, nandIoOe}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);

    // sweep every count and enable
    for (int c = 0; c < 8; c++)
      for (int e = 0; e < 2; e++)
        runOne(8'(8'h10 + c * 16 + e), 8'(8'h30 + c), c, e[0],
               32'hA1B2C3D4 ^ (c * 32'h01010101), 8'(8'h5A + c));

    // canonical page read shape
    runOne(8'h00, 8'h30, 5, 1'b1, 32'h44332211, 8'h55);
    // reset-style lone opcode
    runOne(8'hFF, 8'h00, 0, 1'b0, 32'h0, 8'h00);

    // R11: extra byte snapshot
    loadExt(8'h5C);
    startCapture();
    appendExp(8'h00, 8'h00, 5, 1'b0, 32'h0D0C0B0A, 8'h5C);
    busWrite(mkAddr(8'h00, 8'h00, 5, 1'b0), 32'h0D0C0B0A);
    loadExt(8'hC5);
    waitIdle();
    busyCntEn = 1'b0;
    compareSeq("R11 extra byte snapshot");

    // R7: timeout, ready never falls
    startCapture();
    appendExp(8'h60, 8'hD0, 2, 1'b1, 32'h00001234, 8'h00);
    busWrite(mkAddr(8'h60, 8'hD0, 2, 1'b1), 32'h00001234);
    waitIdle();
    busyCntEn = 1'b0;
    check(busyCnt == expN * (WL + WH) + TMO, "R7 timeout length", busyCnt,
          expN * (WL + WH) + TMO);
    check(busRdData[2] == 1'b1, "R7 timeout flag", busRdData[2], 1);
    readStatus();
    check(busRdData[2] == 1'b0, "R10 timeout cleared", busRdData[2], 0);

    // R8 / R9: queue and overflow
    startCapture();
    appendExp(8'h21, 8'h00, 2, 1'b0, 32'h00007788, 8'h00);
    appendExp(8'h22, 8'h00, 1, 1'b0, 32'h00000099, 8'h00);
    busWrite(mkAddr(8'h21, 8'h00, 2, 1'b0), 32'h00007788);
    busWrite(mkAddr(8'h22, 8'h00, 1, 1'b0), 32'h00000099);
    check(busRdData[1] == 1'b1, "R8 queue full", busRdData[1], 1);
    busWrite(mkAddr(8'h23, 8'h00, 3, 1'b0), 32'hEEEEEEEE);
    check(busRdData[3] == 1'b1, "R9 overflow flag", busRdData[3], 1);
    waitIdle();
    busyCntEn = 1'b0;
    check(busyCnt == 3 * (WL + WH) + 1 + 2 * (WL + WH), "R8 busy continuous",
          busyCnt, 3 * (WL + WH) + 1 + 2 * (WL + WH));
    compareSeq("R9 dropped write absent");
    check(busRdData[1] == 1'b0, "R8 queue drained", busRdData[1], 0);
    check(busRdData[3] == 1'b1, "R10 overflow sticky", busRdData[3], 1);
    readStatus();
    check(busRdData == 32'd0, "R10 flags cleared", busRdData, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule